// File: doc/BRIEF.md
# Packet Slack Priority Estimator

This block sits at a core's network interface and assigns a 5-bit slack tag to each outgoing memory request packet. A lower tag means less slack, so the routers should serve that packet sooner. The block keeps a table of outstanding miss requests. These are the predecessors of any new packet. For each one it stores whether that request was predicted to miss in L2 and how many mesh hops it travels.

When a new request arrives, three values are formed from the predecessor table and packed into the tag. The first is how many predecessors are predicted L2 misses. The second is whether the new packet itself is predicted to hit. The third is how far the longest predecessor trip exceeds the new packet's own trip. The block then records the new request in a free slot and returns that slot number, which is later used to retire the request.

The L2 miss prediction uses a sliding window over the most recent L2 outcomes reported by the training input. A request is predicted to miss when enough of those outcomes were misses.

Requests enter on a valid/ready handshake. `req_ready` falls while every slot is in use. A request presented while `req_ready` is low is not taken, and the requester must hold it until it is taken. The tag is reported as a one-cycle pulse and has no back-pressure. Completion and training inputs are plain strobes that are never refused.

Top module: `pkt_slack_est`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `tag_valid` is high for exactly one cycle, together with `tag` and the slot number `tag_id`. `tag_valid` is low in every other cycle.
- R2: Tag bits [4:3] give the number of predecessors whose stored prediction is L2 miss, saturating at 3.
- R3: Tag bit [2] is 1 when the new packet is predicted to hit in L2, and 0 when it is predicted to miss.
- R4: The hop count of a packet is |dst_x − src_x| + |dst_y − src_y|, using the `src_x`/`src_y` values sampled when the request is accepted.
- R5: Tag bits [1:0] give the largest predecessor hop count minus the new packet's hop count. The result is clamped to 0 when negative and saturates at 3. When there are no predecessors, bits [4:3] and [1:0] are both 0.
- R6: The predictor keeps the last M training outcomes, with M=4 by default. A packet is predicted to miss when at least T of them are misses, with T=3 by default. After reset the history holds only hits.
- R7: The predecessors are the slots that were outstanding at the start of the accepting cycle. The new packet is not one of them. A slot being retired in that same cycle still counts as a predecessor.
- R8: A `cmp_valid` strobe frees slot `cmp_id`. A strobe that names a slot not outstanding, or an id of DEPTH or more, has no effect.
- R9: `req_ready` is low exactly when all DEPTH slots (default 6) are outstanding. A new request takes the lowest-numbered free slot.
- R10: After reset `req_ready` is 1, `tag_valid` is 0 and no slot is outstanding.
- R11: A training outcome given in the same cycle as an accepted request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_x | input | COORD_W | This node's mesh X coordinate |
| src_y | input | COORD_W | This node's mesh Y coordinate |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | A slot is free and the request can be taken |
| req_dst_x | input | COORD_W | Request destination X |
| req_dst_y | input | COORD_W | Request destination Y |
| cmp_valid | input | 1 | Completion strobe |
| cmp_id | input | ID_W | Slot retired by the completion |
| trn_valid | input | 1 | Training strobe |
| trn_l2_miss | input | 1 | Training outcome: 1 means L2 miss |
| tag_valid | output | 1 | Tag pulse for an accepted request |
| tag | output | 5 | Slack tag {pred count, own hit, hop excess} |
| tag_id | output | ID_W | Slot given to the accepted request |

## Verification
The bench targets these corner cases:

- **Empty table.** A design that fed stale hop data into the estimate would give a nonzero hop field here.
- **Own trip longer than every predecessor's.** An unclamped subtraction would wrap to a large value.
- **Four or more predicted-miss predecessors.** A design without saturation would overflow the 2-bit count.
- **Predictor window.** Outcomes that fall out of the window must stop counting, so a predictor that remembered too many outcomes would keep calling misses after they left the window.
- **Full table.** A design that accepted while full would overwrite a live slot.
- **Bad and repeated completions.** A design that acted on them would free a slot wrongly.
- **Same-cycle completion or training.** A design that dropped a retiring predecessor too early, or that used fresh training data too soon, would produce a different tag.

// File: rtl/pkt_slack_pkg.sv
package pkt_slack_pkg;
  localparam int TAG_W = 5;

  typedef struct packed {
    logic [1:0] pred_miss_cnt;
    logic       own_hit;
    logic [1:0] hop_excess;
  } slack_tag_t;

  function automatic logic [1:0] sat3(input int unsigned v);
    return (v > 3) ? 2'd3 : v[1:0];
  endfunction
endpackage

// File: rtl/slack_hop_calc.sv
module slack_hop_calc #(
  parameter int COORD_W = 3,
  parameter int HOP_W   = 4
) (
  input  logic [COORD_W-1:0] sx,
  input  logic [COORD_W-1:0] sy,
  input  logic [COORD_W-1:0] dx,
  input  logic [COORD_W-1:0] dy,
  output logic [HOP_W-1:0]   hops
);
  logic [COORD_W-1:0] ax, ay;

  always_comb begin
    ax   = (dx >= sx) ? (dx - sx) : (sx - dx);
    ay   = (dy >= sy) ? (dy - sy) : (sy - dy);
    hops = HOP_W'(ax) + HOP_W'(ay);
  end
endmodule

// File: rtl/slack_miss_predictor.sv
module slack_miss_predictor #(
  parameter int HIST_M   = 4,
  parameter int THRESH_T = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trn_valid,
  input  logic trn_l2_miss,
  output logic predict_miss
);
  localparam int CNT_W = $clog2(HIST_M + 1);

  logic [HIST_M-1:0] hist;
  logic [CNT_W-1:0]  ones;

  always_ff @(posedge clk) begin
    if (rst)            hist <= '0;
    else if (trn_valid) hist <= {hist[HIST_M-2:0], trn_l2_miss};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_M; i++) ones = ones + CNT_W'(hist[i]);
    predict_miss = (int'(ones) >= THRESH_T);
  end
endmodule

// File: rtl/slack_pred_table.sv
module slack_pred_table #(
  parameter int DEPTH = 6,
  parameter int ID_W  = 3,
  parameter int HOP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic             alloc_miss,
  input  logic [HOP_W-1:0] alloc_hop,
  input  logic             free_en,
  input  logic [ID_W-1:0]  free_id,
  output logic             full,
  output logic [ID_W-1:0]  free_idx,
  output logic [1:0]       miss_cnt,
  output logic [HOP_W-1:0] max_hop,
  output logic [DEPTH-1:0] slot_vld
);
  import pkt_slack_pkg::*;

  logic [DEPTH-1:0] slot_miss;
  logic [HOP_W-1:0] slot_hop [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[g]  <= 1'b0;
        slot_miss[g] <= 1'b0;
        slot_hop[g]  <= '0;
      end else if (alloc_en && free_idx == ID_W'(g)) begin
        slot_vld[g]  <= 1'b1;
        slot_miss[g] <= alloc_miss;
        slot_hop[g]  <= alloc_hop;
      end else if (free_en && free_id == ID_W'(g)) begin
        slot_vld[g]  <= 1'b0;
      end
    end
  end

  always_comb begin
    int unsigned cnt;
    cnt      = 0;
    free_idx = '0;
    max_hop  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_vld[i]) free_idx = ID_W'(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_vld[i]) begin
        if (slot_miss[i]) cnt++;
        if (slot_hop[i] > max_hop) max_hop = slot_hop[i];
      end
    end
    miss_cnt = sat3(cnt);
    full     = &slot_vld;
  end
endmodule

// File: rtl/pkt_slack_est.sv
module pkt_slack_est #(
  parameter int COORD_W  = 3,
  parameter int DEPTH    = 6,
  parameter int HIST_M   = 4,
  parameter int THRESH_T = 3,
  parameter int ID_W     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_dst_x,
  input  logic [COORD_W-1:0] req_dst_y,
  input  logic               cmp_valid,
  input  logic [ID_W-1:0]    cmp_id,
  input  logic               trn_valid,
  input  logic               trn_l2_miss,
  output logic               tag_valid,
  output logic [4:0]         tag,
  output logic [ID_W-1:0]    tag_id
);
  import pkt_slack_pkg::*;

  localparam int MAX_HOP = 2 * ((1 << COORD_W) - 1);
  localparam int HOP_W   = $clog2(MAX_HOP + 1);

  logic             accept, full, pmiss;
  logic [HOP_W-1:0] own_hop, max_hop;
  logic [ID_W-1:0]  free_idx;
  logic [1:0]       miss_cnt;
  logic [DEPTH-1:0] slot_vld;
  slack_tag_t       next_tag;

  slack_hop_calc #(.COORD_W(COORD_W), .HOP_W(HOP_W)) u_hop (
    .sx(src_x), .sy(src_y), .dx(req_dst_x), .dy(req_dst_y), .hops(own_hop)
  );

  slack_miss_predictor #(.HIST_M(HIST_M), .THRESH_T(THRESH_T)) u_pred (
    .clk(clk), .rst(rst), .trn_valid(trn_valid), .trn_l2_miss(trn_l2_miss),
    .predict_miss(pmiss)
  );

  slack_pred_table #(.DEPTH(DEPTH), .ID_W(ID_W), .HOP_W(HOP_W)) u_tab (
    .clk(clk), .rst(rst),
    .alloc_en(accept), .alloc_miss(pmiss), .alloc_hop(own_hop),
    .free_en(cmp_valid), .free_id(cmp_id),
    .full(full), .free_idx(free_idx), .miss_cnt(miss_cnt),
    .max_hop(max_hop), .slot_vld(slot_vld)
  );

  assign req_ready = ~full;
  assign accept    = req_valid & req_ready;

  always_comb begin
    next_tag.pred_miss_cnt = miss_cnt;
    next_tag.own_hit       = ~pmiss;
    if (max_hop > own_hop) next_tag.hop_excess = sat3(int'(max_hop - own_hop));
    else                   next_tag.hop_excess = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_valid <= 1'b0;
      tag       <= '0;
      tag_id    <= '0;
    end else begin
      tag_valid <= accept;
      if (accept) begin
        tag    <= next_tag;
        tag_id <= free_idx;
      end
    end
  end
endmodule

// File: rtl/pkt_slack_est_chk.sv
module pkt_slack_est_chk #(
  parameter int DEPTH = 6,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             tag_valid,
  input logic [4:0]       tag,
  input logic [ID_W-1:0]  tag_id,
  input logic [DEPTH-1:0] slot_vld
);
  a_r1_tag_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> tag_valid);

  a_r1_no_spurious_tag: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !tag_valid);

  a_r5_empty_table_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && slot_vld == '0) |=> (tag[4:3] == 2'd0 && tag[1:0] == 2'd0));

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (int'(tag[4:3]) <= $countones($past(slot_vld))));

  a_r8_slot_taken: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> slot_vld[tag_id]);

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (&slot_vld) |-> !req_ready);
endmodule

bind pkt_slack_est pkt_slack_est_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .tag_valid(tag_valid), .tag(tag), .tag_id(tag_id), .slot_vld(slot_vld)
);

// File: tb/pkt_slack_est_bench.sv
module pkt_slack_est_bench;
  localparam int COORD_W = 3;
  localparam int DEPTH   = 6;
  localparam int HIST_M  = 4;
  localparam int THRESH  = 3;
  localparam int ID_W    = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic [COORD_W-1:0] src_x = 3, src_y = 3, req_dst_x = 0, req_dst_y = 0;
  logic req_valid = 0, cmp_valid = 0, trn_valid = 0, trn_l2_miss = 0;
  logic [ID_W-1:0] cmp_id = 0;
  logic req_ready, tag_valid;
  logic [4:0] tag;
  logic [ID_W-1:0] tag_id;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_vld [DEPTH];
  bit m_miss[DEPTH];
  int m_hop [DEPTH];
  bit m_hist[HIST_M];

  always #4 clk = ~clk;

  pkt_slack_est #(.COORD_W(COORD_W), .DEPTH(DEPTH), .HIST_M(HIST_M), .THRESH_T(THRESH)) u_pkt_slack_est (
    .clk(clk), .rst(rst), .src_x(src_x), .src_y(src_y),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
    .cmp_valid(cmp_valid), .cmp_id(cmp_id),
    .trn_valid(trn_valid), .trn_l2_miss(trn_l2_miss),
    .tag_valid(tag_valid), .tag(tag), .tag_id(tag_id)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // One cycle of stimulus; expectations come from the bench's own model.
  task automatic step(input bit rq, input int x, input int y, input bit cv, input int cid,
                      input bit tv, input bit tm, input string r);
    int cnt, fidx, pm, mx, hop, ones, ex, exp_tag;
    bit acc, pmiss;
    @(negedge clk);
    req_valid = rq; req_dst_x = x[COORD_W-1:0]; req_dst_y = y[COORD_W-1:0];
    cmp_valid = cv; cmp_id = cid[ID_W-1:0];
    trn_valid = tv; trn_l2_miss = tm;
    #1;
    cnt = 0; fidx = -1; pm = 0; mx = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_vld[i]) begin
        cnt++;
        if (m_miss[i]) pm++;
        if (m_hop[i] > mx) mx = m_hop[i];
      end else if (fidx < 0) fidx = i;
    end
    chk(req_ready == (cnt < DEPTH), "R9 ready", req_ready, cnt < DEPTH);
    acc = rq && (cnt < DEPTH);
    ones = 0;
    for (int i = 0; i < HIST_M; i++) ones += m_hist[i];
    pmiss = (ones >= THRESH);
    hop = absd(x, src_x) + absd(y, src_y);
    ex = mx - hop;
    if (ex < 0) ex = 0;
    if (ex > 3) ex = 3;
    exp_tag = ((pm > 3 ? 3 : pm) << 3) | ((pmiss ? 0 : 1) << 2) | ex;
    @(posedge clk);
    #2;
    req_valid = 0; cmp_valid = 0; trn_valid = 0;
    chk(tag_valid == acc, {r, " R1 tag_valid"}, tag_valid, acc);
    if (acc) begin
      chk(int'(tag) == exp_tag, {r, " tag"}, tag, exp_tag);
      chk(int'(tag_id) == fidx, {r, " R9 slot"}, tag_id, fidx);
    end
    if (cv && cid < DEPTH) m_vld[cid] = 0;
    if (acc) begin m_vld[fidx] = 1; m_miss[fidx] = pmiss; m_hop[fidx] = hop; end
    if (tv) begin
      for (int i = HIST_M - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = tm;
    end
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R10 ready after reset", req_ready, 1);
    chk(tag_valid == 0, "R10 tag_valid after reset", tag_valid, 0);
  endtask

  task automatic t_empty_and_hops();
    step(1, 5, 6, 0, 0, 0, 0, "R5 empty list");
    step(1, 3, 3, 0, 0, 0, 0, "R5 saturated excess");
    step(1, 0, 7, 0, 0, 0, 0, "R5 negative clamp R4");
    src_x = 0; src_y = 7;
    step(1, 7, 0, 0, 0, 0, 0, "R4 far corner");
    step(1, 6, 7, 0, 0, 0, 0, "R4 new source");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, i, 0, 0, "R8 retire");
    src_x = 3; src_y = 3;
  endtask

  task automatic t_window();
    step(0, 0, 0, 0, 0, 1, 1, "R6 train");
    step(0, 0, 0, 0, 0, 1, 1, "R6 train");
    step(1, 3, 4, 0, 0, 1, 0, "R6 two of four R11");
    step(1, 3, 4, 0, 0, 1, 1, "R6 still below R11");
    step(1, 4, 4, 0, 0, 0, 0, "R3 predicted miss");
    step(1, 4, 4, 0, 0, 1, 0, "R3 miss R11");
    step(1, 4, 4, 0, 0, 0, 0, "R6 window aged");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, i, 0, 0, "R8 retire");
  endtask

  task automatic t_saturate_full();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 1, "R6 train miss");
    for (int i = 0; i < DEPTH; i++) step(1, i, 7 - i, 0, 0, 0, 0, "R2 count");
    step(1, 1, 1, 0, 0, 0, 0, "R9 held while full");
    step(1, 1, 1, 0, 0, 0, 0, "R9 held while full");
    step(1, 1, 1, 1, 7, 0, 0, "R8 bad id while full");
    step(0, 0, 0, 1, 2, 0, 0, "R8 retire slot 2");
    step(0, 0, 0, 1, 2, 0, 0, "R8 repeat retire");
    step(1, 2, 2, 1, 4, 0, 0, "R7 retiring still counted");
    step(1, 2, 5, 0, 0, 0, 0, "R9 lowest free slot");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, i, 0, 0, "R8 retire");
    step(1, 3, 3, 0, 0, 1, 0, "R7 R5 empty after drain");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_empty_and_hops();
    t_window();
    t_saturate_full();
    idle_n(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule